// File: doc/BRIEF.md
# Four-Phase Interlocked Handshake Link

This block joins a requesting side and a responding side that run on two unrelated clocks. No clock or time slot is shared between them. Each transfer is timed only by two handshake lines. The requester drives the request strobe and the responder drives the acknowledge strobe. Each side passes the opposite strobe through its own two-flop synchroniser before it acts on it.

A transfer runs as follows:
- The requester drives the address, the direction and, for a write, the write data, and holds them for at least one clock.
- The requester raises the request strobe.
- The responder sees the request and waits a programmable number of its own clocks. It then performs the access on its local word array: it stores the write data, or it loads the read word onto the return data lines.
- The responder raises the acknowledge strobe.
- The requester sees the acknowledge. It captures the return data and drops the request.
- The responder sees the request drop. It drops the acknowledge and stops driving the return data.
- The requester sees the acknowledge drop and reports completion with a one-clock pulse.

No step counts a fixed number of clocks. The link therefore works with a responder of any speed and needs no reconfiguration.

Top module: `hs_link`

## Requirements
- R1: After reset, both strobes are low, `req_ready` is high, `done` is low, and every word of the responder array reads as zero.
- R2: The request strobe rises only after the address, direction and write data have been driven for at least one requester clock, and only while the synchronised acknowledge is low. The address stays stable while the request strobe is high.
- R3: Once the request strobe is high, it stays high until the requester has seen the acknowledge high. It then falls.
- R4: The acknowledge rises only while the responder sees the request high. Before it rises, the responder waits `slv_delay` responder clocks and performs the access.
- R5: Once the acknowledge is high, it stays high until the responder has seen the request low. The return data stays stable for as long as the acknowledge is high.
- R6: A write (`req_write` = 1) stores `req_wdata` at `req_addr` in the responder array.
- R7: A read (`req_write` = 0) returns the word at `req_addr` on `rdata`.
- R8: `done` is a one-clock pulse. It is raised after the requester sees the acknowledge low, and `rdata` holds the captured read word in that cycle.
- R9: A request is accepted only while `req_ready` is high. `req_valid` asserted while a transfer is in progress has no effect.
- R10: Every responder delay from 0 to 15 gives the same data results. The completion time grows with the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester-side clock |
| rst_m_n | input | 1 | Requester-side active-low reset |
| clk_s | input | 1 | Responder-side clock |
| rst_s_n | input | 1 | Responder-side active-low reset |
| req_valid | input | 1 | Start a transfer (taken when `req_ready` is high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Requester is idle and can accept a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read word, valid with `done` after a read |
| slv_delay | input | 4 | Responder access delay in responder clocks |
| msync_mon | output | 1 | Request strobe as seen on the link |
| ssync_mon | output | 1 | Acknowledge strobe as seen on the link |

## Verification
The assertions check the local half of the interlock on every cycle:
- the request is held until the acknowledge is seen, and the acknowledge is held until the request release is seen;
- a new request never starts while the acknowledge is still high;
- the address and the return data stay stable inside their windows;
- `done` is a single-cycle pulse.

Some behaviour only the bench scenarios can show. Data integrity across every address and several responder delays is one such case. Others are the ordering of the four strobe edges as seen across the two clock domains, the growth of latency with the delay, and a request raised mid-transfer being ignored.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_SETUP,
        M_WAIT_ACK,
        M_WAIT_REL
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COUNT,
        S_LOAD,
        S_ACK
    } slv_state_e;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_link_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          ready_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          bus_rd_o,
    output logic          msync_o,
    input  logic          ssync_i,
    input  logic [DW-1:0] bus_rdata_i
);
    typedef struct packed {
        mst_state_e    state;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          rd;
        logic          msync;
        logic          done;
        logic [DW-1:0] rdata;
    } mst_regs_t;

    mst_regs_t q, d;
    logic      ss_seen;

    hs_sync2 u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ssync_i),
        .sync_o  (ss_seen)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            M_IDLE: begin
                if (req_valid_i) begin
                    d.addr  = req_addr_i;
                    d.wdata = req_wdata_i;
                    d.rd    = !req_write_i;
                    d.state = M_SETUP;
                end
            end
            M_SETUP: begin
                if (!ss_seen) begin
                    d.msync = 1'b1;
                    d.state = M_WAIT_ACK;
                end
            end
            M_WAIT_ACK: begin
                if (ss_seen) begin
                    if (q.rd) d.rdata = bus_rdata_i;
                    d.msync = 1'b0;
                    d.rd    = 1'b0;
                    d.state = M_WAIT_REL;
                end
            end
            M_WAIT_REL: begin
                if (!ss_seen) begin
                    d.done  = 1'b1;
                    d.state = M_IDLE;
                end
            end
            default: d.state = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= M_IDLE;
            q.addr  <= '0;
            q.wdata <= '0;
            q.rd    <= 1'b0;
            q.msync <= 1'b0;
            q.done  <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_o     = (q.state == M_IDLE);
    assign done_o      = q.done;
    assign rdata_o     = q.rdata;
    assign bus_addr_o  = q.addr;
    assign bus_wdata_o = q.wdata;
    assign bus_rd_o    = q.rd;
    assign msync_o     = q.msync;

    // R3: request held until acknowledge is seen
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.msync && !ss_seen |=> q.msync);

    // R2: a new request never starts while the acknowledge is still seen high
    p_req_rise_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.msync) |-> !ss_seen);

    // R2: address stable while the request is up
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.msync && $past(q.msync) |-> $stable(bus_addr_o));

    // R8: completion is a single pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R8: completion only after the acknowledge is released
    p_done_after_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !ss_seen && !q.msync);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_link_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             msync_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic             bus_rd_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic             ssync_o,
    output logic [DW-1:0]    bus_rdata_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        slv_state_e                 state;
        logic [DLY_W-1:0]           cnt;
        logic [AW-1:0]              addr;
        logic                       rd;
        logic [DW-1:0]              wdata;
        logic [DW-1:0]              rdata;
        logic                       ssync;
        logic [DEPTH-1:0][DW-1:0]   mem;
    } slv_regs_t;

    slv_regs_t q, d;
    logic      ms_seen;

    hs_sync2 u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (msync_i),
        .sync_o  (ms_seen)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE: begin
                if (ms_seen) begin
                    d.addr  = bus_addr_i;
                    d.rd    = bus_rd_i;
                    d.wdata = bus_wdata_i;
                    d.cnt   = delay_i;
                    d.state = S_COUNT;
                end
            end
            S_COUNT: begin
                if (q.cnt == '0) begin
                    if (q.rd) d.rdata       = q.mem[q.addr];
                    else      d.mem[q.addr] = q.wdata;
                    d.state = S_LOAD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_LOAD: begin
                d.ssync = 1'b1;
                d.state = S_ACK;
            end
            S_ACK: begin
                if (!ms_seen) begin
                    d.ssync = 1'b0;
                    d.rdata = '0;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_IDLE;
            q.cnt   <= '0;
            q.addr  <= '0;
            q.rd    <= 1'b0;
            q.wdata <= '0;
            q.rdata <= '0;
            q.ssync <= 1'b0;
            q.mem   <= '0;
        end else begin
            q <= d;
        end
    end

    assign ssync_o     = q.ssync;
    assign bus_rdata_o = q.rdata;

    // R4: acknowledge rises only while the request is seen
    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ssync) |-> ms_seen);

    // R5: acknowledge held until the request release is seen
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ssync && ms_seen |=> q.ssync);

    // R5: return data stable while acknowledge is up
    p_rdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ssync && $past(q.ssync) |-> $stable(bus_rdata_o));

    // R5: acknowledge falls only after the request is seen low
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ssync) |-> !ms_seen);
endmodule

// File: rtl/hs_link.sv
module hs_link #(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk_m,
    input  logic             rst_m_n,
    input  logic             clk_s,
    input  logic             rst_s_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             done,
    output logic [DW-1:0]    rdata,
    input  logic [DLY_W-1:0] slv_delay,
    output logic             msync_mon,
    output logic             ssync_mon
);
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_rd;
    logic          line_msync;
    logic          line_ssync;

    hs_master #(.AW(AW), .DW(DW)) u_master (
        .clk         (clk_m),
        .rst_n       (rst_m_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .ready_o     (req_ready),
        .done_o      (done),
        .rdata_o     (rdata),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_rd_o    (bus_rd),
        .msync_o     (line_msync),
        .ssync_i     (line_ssync),
        .bus_rdata_i (bus_rdata)
    );

    hs_slave #(.AW(AW), .DW(DW), .DLY_W(DLY_W)) u_slave (
        .clk         (clk_s),
        .rst_n       (rst_s_n),
        .delay_i     (slv_delay),
        .msync_i     (line_msync),
        .bus_addr_i  (bus_addr),
        .bus_rd_i    (bus_rd),
        .bus_wdata_i (bus_wdata),
        .ssync_o     (line_ssync),
        .bus_rdata_o (bus_rdata)
    );

    assign msync_mon = line_msync;
    assign ssync_mon = line_ssync;
endmodule

// File: tb/hs_link_tb_top.sv
`timescale 1ns/1ps
module hs_link_tb_top;
    logic       clk_m = 1'b0;
    logic       clk_s = 1'b0;
    logic       rst_m_n = 1'b0;
    logic       rst_s_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic       done;
    logic [7:0] rdata;
    logic [3:0] slv_delay = '0;
    logic       msync_mon;
    logic       ssync_mon;

    int total = 0;
    int bad   = 0;
    bit mon_en = 1'b0;

    always #2   clk_m = ~clk_m;
    always #3.5 clk_s = ~clk_s;

    hs_link dut_i (
        .clk_m     (clk_m),
        .rst_m_n   (rst_m_n),
        .clk_s     (clk_s),
        .rst_s_n   (rst_s_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata),
        .slv_delay (slv_delay),
        .msync_mon (msync_mon),
        .ssync_mon (ssync_mon)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Four-edge interlock order seen across both domains (R2, R3, R4, R5)
    always @(posedge msync_mon) if (mon_en) check("R2 req rise with ack low", ssync_mon, 0);
    always @(posedge ssync_mon) if (mon_en) check("R4 ack rise with req high", msync_mon, 1);
    always @(negedge msync_mon) if (mon_en) check("R3 req fall with ack high", ssync_mon, 1);
    always @(negedge ssync_mon) if (mon_en) check("R5 ack fall with req low", msync_mon, 0);

    // Single transfer; returns read word and cycles from request to done
    task automatic xfer(input bit wr, input logic [3:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int cyc);
        int n;
        @(negedge clk_m);
        while (!req_ready) @(negedge clk_m);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk_m);
        req_valid = 1'b0;
        n = 1;
        while (!done && n < 2000) begin
            @(negedge clk_m);
            n++;
        end
        if (!done) check("R8 transfer timeout", 0, 1);
        else begin
            @(posedge clk_m);
            @(negedge clk_m);
            check("R8 done single pulse", done, 0);
        end
        rd  = rdata;
        cyc = n;
    endtask

    initial begin
        #700000;
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] r;
        int         c;
        int         c_fast;
        int         c_slow;
        logic [7:0] shadow [16];

        repeat (4) @(negedge clk_m);
        rst_m_n = 1'b1;
        rst_s_n = 1'b1;
        repeat (3) @(negedge clk_m);
        check("R1 reset msync", msync_mon, 0);
        check("R1 reset ssync", ssync_mon, 0);
        check("R1 reset ready", req_ready, 1);
        check("R1 reset done",  done, 0);
        mon_en = 1'b1;

        // R1: array is zero after reset
        for (int a = 0; a < 16; a++) begin
            xfer(1'b0, a[3:0], 8'h00, r, c);
            check("R1 R7 reset word zero", r, 0);
            shadow[a] = 8'h00;
        end

        // R6 R7 R10: sweep every address over several responder delays
        for (int k = 0; k < 4; k++) begin
            int dl;
            dl = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 6 : 15;
            slv_delay = dl[3:0];
            for (int a = 0; a < 16; a++) begin
                logic [7:0] v;
                v = 8'((a * 29 + dl * 11 + 3) ^ (k << 6));
                xfer(1'b1, a[3:0], v, r, c);
                shadow[a] = v;
            end
            for (int a = 15; a >= 0; a--) begin
                xfer(1'b0, a[3:0], 8'h00, r, c);
                check("R6 R7 R10 readback", r, shadow[a]);
            end
        end

        // R10: latency grows with delay, results unchanged
        slv_delay = 4'd0;
        xfer(1'b0, 4'd9, 8'h00, r, c_fast);
        check("R10 fast read data", r, shadow[9]);
        slv_delay = 4'd15;
        xfer(1'b0, 4'd9, 8'h00, r, c_slow);
        check("R10 slow read data", r, shadow[9]);
        check("R10 latency grows", (c_slow > c_fast + 15) ? 1 : 0, 1);

        // R9: request raised mid-transfer is ignored
        slv_delay = 4'd8;
        @(negedge clk_m);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd5; req_wdata = 8'h00;
        @(negedge clk_m);
        req_valid = 1'b0;
        repeat (3) @(negedge clk_m);
        check("R9 busy not ready", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd5; req_wdata = 8'hEE;
        repeat (2) @(negedge clk_m);
        req_valid = 1'b0;
        begin
            int n;
            n = 0;
            while (!done && n < 2000) begin @(negedge clk_m); n++; end
            check("R9 R8 first done seen", done, 1);
            check("R9 R8 rdata with done", rdata, shadow[5]);
        end
        repeat (40) @(negedge clk_m);
        check("R9 no extra transfer", req_ready, 1);
        xfer(1'b0, 4'd5, 8'h00, r, c);
        check("R9 word untouched", r, shadow[5]);

        // R6: write then a write-only follow-up keeps other words
        slv_delay = 4'd3;
        xfer(1'b1, 4'd0, 8'hA5, r, c);
        xfer(1'b1, 4'd15, 8'h5A, r, c);
        xfer(1'b0, 4'd0, 8'h00, r, c);
        check("R6 low word", r, 8'hA5);
        xfer(1'b0, 4'd15, 8'h00, r, c);
        check("R6 high word", r, 8'h5A);
        xfer(1'b0, 4'd7, 8'h00, r, c);
        check("R6 neighbour intact", r, shadow[7]);

        repeat (5) @(negedge clk_m);
        finish_run();
    end
endmodule